// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the low address bits for a four-beat burst in a pipelined synchronous SRAM. An address strobe captures a full address. The low two bits of that address become the first beat offset. The upper bits are held on the output, unchanged, for the rest of the burst.

Each later cycle with the advance input high steps the output to the next offset in the burst. Two orderings are available:

- **Interleaved:** the offset is the start offset XOR the beat number.
- **Linear:** the offset is the start offset plus the beat number, modulo four.

A one-bit mode input chooses the ordering. High selects interleaved; a board that leaves the pin open is expected to pull it high. Low selects linear. The mode is captured only at the strobe.

After the fourth beat, a further advance returns the output to the start offset and the cycle repeats. The block also drives two flags:

- a last-beat flag, high while the fourth beat is presented;
- an active flag, which shows that a start address has been loaded since reset.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset, `addr_o` is all zeros, and `last_o` and `active_o` are low.
- R2: A cycle with `strobe_i` high makes `addr_o` equal to that cycle's `addr_i` from the next cycle on. In that next cycle `active_o` is high and `last_o` is low.
- R3: With `mode_i` high at the strobe (interleaved), beat n (n = 0..3) presents offset `start ^ n` on `addr_o[1:0]`. For example, start 01 gives 01, 00, 11, 10.
- R4: With `mode_i` low at the strobe (linear), beat n presents offset `(start + n) mod 4`. For example, start 10 gives 10, 11, 00, 01.
- R5: An advance while the fourth beat (n = 3) is presented returns the offset to the start offset, and the four-beat order repeats.
- R6: `last_o` is high exactly while beat 3 is presented.
- R7: A cycle with neither `strobe_i` nor `advance_i` high leaves `addr_o`, `last_o` and `active_o` unchanged.
- R8: When `strobe_i` and `advance_i` are high in the same cycle, the strobe wins. The next cycle presents beat 0 of the new address, with `last_o` low.
- R9: Changing `mode_i` between strobes has no effect on the order of the burst in progress.
- R10: `advance_i` pulses before the first strobe after reset leave all outputs at their reset values.
- R11: `addr_o` above bit 1 holds the upper bits captured at the strobe, unchanged by advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Address strobe: load `addr_i` and restart at beat 0 |
| addr_i | input | ADDR_W | Address presented with the strobe |
| advance_i | input | 1 | Step to the next beat |
| mode_i | input | 1 | Burst order: 1 = interleaved, 0 = linear; sampled at the strobe |
| addr_o | output | ADDR_W | Current burst address: held upper bits plus the beat offset |
| last_o | output | 1 | High while beat 3 is presented |
| active_o | output | 1 | High once a start address has been loaded |

## Verification
Loading a new start address and stepping to the next beat can be requested in the same clock.

The bench provokes this collision in two ways:

- It raises `strobe_i` and `advance_i` together in the middle of a burst.
- It repeats this while the last beat is showing, when the advance would otherwise wrap the burst.

In both cases it judges the next cycle's outputs: `addr_o` must be the fresh address at beat 0, with `last_o` low. It also checks that the following advance gives beat 1 of the new order, not a beat of the old burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Beat ordering, fixed per burst at the address strobe.
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_offset_gen.sv
// Maps a start offset and a beat index to the offset presented for that beat.
module burst_offset_gen
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e        order,
  input  logic [BEAT_W-1:0]   start,
  input  logic [BEAT_W-1:0]   beat,
  output logic [BEAT_W-1:0]   offset
);

  logic [BEAT_W-1:0] xor_off;
  logic [BEAT_W-1:0] add_off;

  // Interleaved: each beat-index bit flips the matching offset bit.
  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_off[b] = start[b] ^ beat[b];
  end

  // Linear: the sum wraps naturally at the field width.
  assign add_off = start + beat;

  always_comb begin
    if (order == ORD_INTERLEAVED) offset = xor_off;
    else                          offset = add_off;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat index within the burst; cleared on load, wraps on step.
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] cnt_q,
  output logic [BEAT_W-1:0] cnt_next
);

  assign cnt_next = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= '0;
    else if (step) cnt_q <= cnt_next;
  end

endmodule

// File: rtl/burst_addr_seq.sv
// Burst address sequencer: holds the upper address and steps the low offset.
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              advance_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              active_o
);

  localparam int UPPER_W = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

  logic [BEAT_W-1:0]  start_q;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  offset_q;
  burst_order_e       order_q;
  logic               active_q;
  logic               last_q;

  logic              load;
  logic              step;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_next;
  logic [BEAT_W-1:0] offset_next;

  // A strobe outranks an advance in the same cycle.
  assign load = strobe_i;
  assign step = advance_i & active_q & ~strobe_i;

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .step     (step),
    .cnt_q    (beat_q),
    .cnt_next (beat_next)
  );

  burst_offset_gen #(.BEAT_W(BEAT_W)) u_gen (
    .order  (order_q),
    .start  (start_q),
    .beat   (beat_next),
    .offset (offset_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      upper_q  <= '0;
      offset_q <= '0;
      order_q  <= ORD_LINEAR;
      active_q <= 1'b0;
      last_q   <= 1'b0;
    end else if (load) begin
      start_q  <= addr_i[BEAT_W-1:0];
      upper_q  <= addr_i[ADDR_W-1:BEAT_W];
      offset_q <= addr_i[BEAT_W-1:0];
      order_q  <= burst_order_e'(mode_i);
      active_q <= 1'b1;
      last_q   <= 1'b0;
    end else if (step) begin
      offset_q <= offset_next;
      last_q   <= (beat_next == LAST_BEAT);
    end
  end

  assign addr_o   = {upper_q, offset_q};
  assign last_o   = last_q;
  assign active_o = active_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Port-level checker, bound to burst_addr_seq.
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              advance_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              last_o,
  input logic              active_o
);

  // Checker-side record of the burst, built from the ports only.
  logic [BEAT_W-1:0] ref_start;
  logic [BEAT_W-1:0] ref_beat;
  logic              ref_mode;
  logic              ref_loaded;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_start  <= '0;
      ref_beat   <= '0;
      ref_mode   <= 1'b0;
      ref_loaded <= 1'b0;
    end else if (strobe_i) begin
      ref_start  <= addr_i[BEAT_W-1:0];
      ref_beat   <= '0;
      ref_mode   <= mode_i;
      ref_loaded <= 1'b1;
    end else if (advance_i && ref_loaded) begin
      ref_beat   <= ref_beat + 1'b1;
    end
  end

  logic [BEAT_W-1:0] ref_lin;
  assign ref_lin = ref_start + ref_beat;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> (addr_o == $past(addr_i)) && active_o && !last_o);

  assert_interleave_R3: assert property (@(posedge clk) disable iff (rst)
    (ref_loaded && ref_mode) |-> (addr_o[BEAT_W-1:0] == (ref_start ^ ref_beat)));

  assert_linear_R4: assert property (@(posedge clk) disable iff (rst)
    (ref_loaded && !ref_mode) |-> (addr_o[BEAT_W-1:0] == ref_lin));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (active_o && last_o && advance_i && !strobe_i) |=> (addr_o[BEAT_W-1:0] == ref_start) && !last_o);

  assert_last_R6: assert property (@(posedge clk) disable iff (rst)
    ref_loaded |-> (last_o == (ref_beat == {BEAT_W{1'b1}})));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!strobe_i && !advance_i) |=> $stable(addr_o) && $stable(last_o) && $stable(active_o));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && advance_i) |=> !last_o && (addr_o[BEAT_W-1:0] == $past(addr_i[BEAT_W-1:0])));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !strobe_i) |=> !active_o && $stable(addr_o) && !last_o);

  assert_upper_R11: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .strobe_i  (strobe_i),
  .addr_i    (addr_i),
  .advance_i (advance_i),
  .mode_i    (mode_i),
  .addr_o    (addr_o),
  .last_o    (last_o),
  .active_o  (active_o)
);

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;

  localparam int ADDR_W = 20;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              strobe_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              advance_i = 1'b0;
  logic              mode_i = 1'b1;
  logic [ADDR_W-1:0] addr_o;
  logic              last_o;
  logic              active_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .addr_i(addr_i),
    .advance_i(advance_i), .mode_i(mode_i),
    .addr_o(addr_o), .last_o(last_o), .active_o(active_o)
  );

  // {mode, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 2'b00, 2'b00, 2'b01, 2'b10, 2'b11},
    {1'b1, 2'b01, 2'b01, 2'b00, 2'b11, 2'b10},
    {1'b1, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01},
    {1'b1, 2'b11, 2'b11, 2'b10, 2'b01, 2'b00},
    {1'b0, 2'b00, 2'b00, 2'b01, 2'b10, 2'b11},
    {1'b0, 2'b01, 2'b01, 2'b10, 2'b11, 2'b00},
    {1'b0, 2'b10, 2'b10, 2'b11, 2'b00, 2'b01},
    {1'b0, 2'b11, 2'b11, 2'b00, 2'b01, 2'b10}
  };

  task automatic check(input string req, input logic [ADDR_W+1:0] act,
                       input logic [ADDR_W+1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive inputs, let one rising edge pass, then settle 1 ns after it.
  task automatic cyc(input logic s, input logic a, input logic [ADDR_W-1:0] ad,
                     input logic m);
    strobe_i = s; advance_i = a; addr_i = ad; mode_i = m;
    @(posedge clk); #1;
    strobe_i = 1'b0; advance_i = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-BEAT_W-1:0] up;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    check("R1", {addr_o, last_o, active_o}, '0);

    // R10 advance before first strobe is ignored
    cyc(1'b0, 1'b1, 20'hABCDE, 1'b1);
    cyc(1'b0, 1'b1, 20'h12345, 1'b0);
    check("R10", {addr_o, last_o, active_o}, '0);

    // Vector walk: R2 R3 R4 R5 R6 R9 R11
    for (int i = 0; i < 8; i++) begin
      logic m;
      logic [1:0] st;
      logic [1:0] e [4];
      m = VEC[i][10]; st = VEC[i][9:8];
      e[0] = VEC[i][7:6]; e[1] = VEC[i][5:4]; e[2] = VEC[i][3:2]; e[3] = VEC[i][1:0];
      up = 18'h155A0 + 18'(i * 7);
      cyc(1'b1, 1'b0, {up, st}, m);
      check("R2", {addr_o, last_o, active_o}, {up, e[0], 1'b0, 1'b1});
      for (int b = 1; b < 4; b++) begin
        // R9: flip mode mid-burst; order must not change
        cyc(1'b0, 1'b1, 20'hFFFFF, ~m);
        check(m ? "R3" : "R4", {addr_o, last_o, active_o},
              {up, e[b], (b == 3), 1'b1});
      end
      check("R6", {31'd0, last_o}, 32'd1);
      cyc(1'b0, 1'b1, 20'h00000, ~m);
      check("R5", {addr_o, last_o, active_o}, {up, e[0], 1'b0, 1'b1});
      cyc(1'b0, 1'b1, 20'h00000, m);
      check("R11", {addr_o, last_o, active_o}, {up, e[1], 1'b0, 1'b1});
    end

    // R7 hold with idle cycles
    up = 18'h2BEEF;
    cyc(1'b1, 1'b0, {up, 2'b10}, 1'b0);
    cyc(1'b0, 1'b1, 20'h0, 1'b0);
    cyc(1'b0, 1'b0, 20'h3FFFF, 1'b1);
    cyc(1'b0, 1'b0, 20'h00001, 1'b0);
    check("R7", {addr_o, last_o, active_o}, {up, 2'b11, 1'b0, 1'b1});

    // R8 strobe with advance mid-burst: new start wins, beat 0
    up = 18'h01234;
    cyc(1'b1, 1'b1, {up, 2'b01}, 1'b1);
    check("R8", {addr_o, last_o, active_o}, {up, 2'b01, 1'b0, 1'b1});
    cyc(1'b0, 1'b1, 20'h0, 1'b0);
    check("R8", {addr_o, last_o, active_o}, {up, 2'b00, 1'b0, 1'b1});

    // R8 collision on the last beat (would otherwise wrap)
    cyc(1'b0, 1'b1, 20'h0, 1'b0);
    cyc(1'b0, 1'b1, 20'h0, 1'b0);
    check("R6", {addr_o, last_o, active_o}, {up, 2'b10, 1'b1, 1'b1});
    cyc(1'b1, 1'b1, {18'h3C3C3, 2'b11}, 1'b0);
    check("R8", {addr_o, last_o, active_o}, {18'h3C3C3, 2'b11, 1'b0, 1'b1});
    cyc(1'b0, 1'b1, 20'h0, 1'b1);
    check("R4", {addr_o, last_o, active_o}, {18'h3C3C3, 2'b00, 1'b0, 1'b1});

    // R1 reset mid-burst
    rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    check("R1", {addr_o, last_o, active_o}, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule